// File: doc/BRIEF.md
# Unlock Command Sequence Decoder

This block sits beside a sector-programmed nonvolatile array and watches every word load the host makes. It spots short key sequences: fixed data words written to fixed addresses in a fixed order. It uses them to keep two pieces of state. The first is a write-protect flag, which tells the sector write engine whether the loads of the current program period may really change the array. The second is an identification mode, in which reads of the two lowest addresses return fixed manufacturer and device codes instead of array contents.

All keys share a two-load prefix: 0xAAAA written to 0x5555, then 0x5555 written to 0x2AAA. A third load to 0x5555 picks the action:
- 0xA0A0 enables protection and authorises the current period.
- 0x9090 enters identification mode.
- 0xF0F0 leaves identification mode.
- 0x8080 opens a longer path. That path needs the prefix again and then 0x2020 to 0x5555, and it disables protection.

Changes to protection take effect only when the write engine reports that a program period is complete. Changes to identification mode take effect after a fixed wait, counted in clock cycles.

Top module: `unlock_seq_decoder`

## Requirements
- R1: Key addresses are compared on `ld_addr[14:0]` only, so bit 15 of a load address has no effect on matching. The prefix is data 0xAAAA at address 0x5555, then data 0x5555 at address 0x2AAA.
- R2: The prefix followed by 0xA0A0 at 0x5555 drives `wr_allow` high from the next cycle. At the next `prog_done` pulse, `prot_on` goes to 1, even if no sector data was loaded.
- R3: Six loads disable protection: the prefix, 0x8080 at 0x5555, the prefix again, then 0x2020 at 0x5555. After the sixth load, `wr_allow` is 1 for the rest of the period. At the next `prog_done` pulse, `prot_on` goes to 0.
- R4: While `prot_on` is 1 and no key has authorised the current period, `wr_allow` is 0. Any authorisation ends with the `prog_done` pulse that closes the period.
- R5: `prot_on` powers up at 0, changes only in the cycle after a `prog_done` pulse, and is not changed by `rst`.
- R6: A load that does not continue the sequence in progress returns the matcher to idle. That same load is then tested as a first step, so it can start a new sequence.
- R7: After the final load of the identification enter or exit key, `id_mode` takes its new value exactly `ID_WAIT` clock edges later, and not before.
- R8: While `id_mode` is 1 and `rd_addr[15:1]` is zero, `rd_data` is 0x001F when `rd_addr[0]` is 0 and 0x0025 when it is 1. In every other case, `rd_data` equals `arr_rdata`.
- R9: `rst` clears `id_mode`, any identification change still waiting, and any partial sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_valid | input | 1 | One-cycle strobe marking a word load |
| ld_addr | input | 16 | Address of the load |
| ld_data | input | 16 | Data of the load |
| prog_done | input | 1 | Pulse: the current program period has finished |
| rd_addr | input | 16 | Read address |
| arr_rdata | input | 16 | Array data for `rd_addr` |
| rd_data | output | 16 | Read data after identification substitution |
| wr_allow | output | 1 | Loads of this period may alter the array |
| prot_on | output | 1 | Write protection is in force |
| id_mode | output | 1 | Identification mode is active |

## Verification
The bench builds the block with `ID_WAIT` set to 6, so the wait before an identification change can be checked edge by edge: one cycle early and exactly on time. The default, 50000, stands for a long real-time pause and is only elaborated. With the short wait, a reset can also be placed in the middle of a pending change, and the bench can show that reset abandons it.

// File: rtl/unlock_pkg.sv
package unlock_pkg;

    localparam int WORD_W = 16;

    localparam logic [14:0] KEY_ADDR_A = 15'h5555;
    localparam logic [14:0] KEY_ADDR_B = 15'h2AAA;

    localparam logic [WORD_W-1:0] KEY_D_PRE1   = 16'hAAAA;
    localparam logic [WORD_W-1:0] KEY_D_PRE2   = 16'h5555;
    localparam logic [WORD_W-1:0] KEY_D_PROT   = 16'hA0A0;
    localparam logic [WORD_W-1:0] KEY_D_LONG   = 16'h8080;
    localparam logic [WORD_W-1:0] KEY_D_UNPROT = 16'h2020;
    localparam logic [WORD_W-1:0] KEY_D_IDIN   = 16'h9090;
    localparam logic [WORD_W-1:0] KEY_D_IDOUT  = 16'hF0F0;

    localparam logic [WORD_W-1:0] CODE_MAKER  = 16'h001F;
    localparam logic [WORD_W-1:0] CODE_DEVICE = 16'h0025;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_P1,
        ST_P2,
        ST_LONG,
        ST_Q1,
        ST_Q2
    } step_t;

    typedef struct packed {
        logic prot_set;
        logic prot_clr;
        logic id_enter;
        logic id_leave;
    } key_evt_t;

    function automatic logic at_a(input logic [WORD_W-1:0] a);
        return a[14:0] == KEY_ADDR_A;
    endfunction

    function automatic logic at_b(input logic [WORD_W-1:0] a);
        return a[14:0] == KEY_ADDR_B;
    endfunction

    function automatic logic is_opener(input logic [WORD_W-1:0] a,
                                       input logic [WORD_W-1:0] d);
        return at_a(a) && (d == KEY_D_PRE1);
    endfunction

endpackage

// File: rtl/unlock_step_fsm.sv
module unlock_step_fsm
    import unlock_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_valid,
    input  logic [WORD_W-1:0] ld_addr,
    input  logic [WORD_W-1:0] ld_data,
    output key_evt_t          evt
);

    step_t state_q, state_d;
    step_t restart;

    always_comb begin
        restart = is_opener(ld_addr, ld_data) ? ST_P1 : ST_IDLE;
        state_d = state_q;
        evt     = '0;
        if (ld_valid) begin
            state_d = restart;
            unique case (state_q)
                ST_IDLE: state_d = restart;
                ST_P1: if (at_b(ld_addr) && ld_data == KEY_D_PRE2) state_d = ST_P2;
                ST_P2: if (at_a(ld_addr)) begin
                    if (ld_data == KEY_D_PROT) begin
                        evt.prot_set = 1'b1;
                        state_d      = ST_IDLE;
                    end else if (ld_data == KEY_D_LONG) begin
                        state_d = ST_LONG;
                    end else if (ld_data == KEY_D_IDIN) begin
                        evt.id_enter = 1'b1;
                        state_d      = ST_IDLE;
                    end else if (ld_data == KEY_D_IDOUT) begin
                        evt.id_leave = 1'b1;
                        state_d      = ST_IDLE;
                    end
                end
                ST_LONG: if (is_opener(ld_addr, ld_data)) state_d = ST_Q1;
                ST_Q1: if (at_b(ld_addr) && ld_data == KEY_D_PRE2) state_d = ST_Q2;
                ST_Q2: if (at_a(ld_addr) && ld_data == KEY_D_UNPROT) begin
                    evt.prot_clr = 1'b1;
                    state_d      = ST_IDLE;
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // R3/R7: at most one key completes per load
    a_r3_single_event: assert property (@(posedge clk) disable iff (rst)
        $onehot0({evt.prot_set, evt.prot_clr, evt.id_enter, evt.id_leave}));

    // R6: a load to neither key address leaves the matcher idle
    a_r6_offkey_idle: assert property (@(posedge clk) disable iff (rst)
        (ld_valid && !at_a(ld_addr) && !at_b(ld_addr)) |=> state_q == ST_IDLE);

endmodule

// File: rtl/unlock_id_timer.sv
module unlock_id_timer #(
    parameter int WAIT = 50000
) (
    input  logic clk,
    input  logic rst,
    input  logic go,
    input  logic go_target,
    output logic mode
);

    localparam int CNT_W = $clog2(WAIT + 1);

    logic [CNT_W-1:0] cnt_q;
    logic             tgt_q;
    logic             mode_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            tgt_q  <= 1'b0;
            mode_q <= 1'b0;
        end else if (go) begin
            cnt_q <= CNT_W'(WAIT);
            tgt_q <= go_target;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == CNT_W'(1)) mode_q <= tgt_q;
        end
    end

    assign mode = mode_q;

    // R7: mode cannot move while more than one cycle of wait remains
    a_r7_hold_while_waiting: assert property (@(posedge clk) disable iff (rst)
        (cnt_q > CNT_W'(1)) |=> $stable(mode_q));

    // R7: with no wait pending and no new request, mode stays put
    a_r7_hold_when_quiet: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == '0 && !go) |=> $stable(mode_q));

endmodule

// File: rtl/unlock_seq_decoder.sv
module unlock_seq_decoder
    import unlock_pkg::*;
#(
    parameter int ID_WAIT = 50000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        ld_valid,
    input  logic [15:0] ld_addr,
    input  logic [15:0] ld_data,
    input  logic        prog_done,
    input  logic [15:0] rd_addr,
    input  logic [15:0] arr_rdata,
    output logic [15:0] rd_data,
    output logic        wr_allow,
    output logic        prot_on,
    output logic        id_mode
);

    key_evt_t evt;
    logic     prot_q = 1'b0;
    logic     pend_set_q, pend_clr_q, auth_q;
    logic     prot_evt;

    unlock_step_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .ld_valid (ld_valid),
        .ld_addr  (ld_addr),
        .ld_data  (ld_data),
        .evt      (evt)
    );

    unlock_id_timer #(.WAIT(ID_WAIT)) u_idt (
        .clk       (clk),
        .rst       (rst),
        .go        (evt.id_enter | evt.id_leave),
        .go_target (evt.id_enter),
        .mode      (id_mode)
    );

    assign prot_evt = evt.prot_set | evt.prot_clr;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_set_q <= 1'b0;
            pend_clr_q <= 1'b0;
            auth_q     <= 1'b0;
        end else if (prot_evt) begin
            pend_set_q <= evt.prot_set;
            pend_clr_q <= evt.prot_clr;
            auth_q     <= 1'b1;
        end else if (prog_done) begin
            pend_set_q <= 1'b0;
            pend_clr_q <= 1'b0;
            auth_q     <= 1'b0;
        end
    end

    // protection state survives reset on purpose
    always_ff @(posedge clk) begin
        if (prog_done) begin
            if (pend_set_q)      prot_q <= 1'b1;
            else if (pend_clr_q) prot_q <= 1'b0;
        end
    end

    assign prot_on  = prot_q;
    assign wr_allow = !prot_q || auth_q;

    always_comb begin
        rd_data = arr_rdata;
        if (id_mode && rd_addr[15:1] == '0)
            rd_data = rd_addr[0] ? CODE_DEVICE : CODE_MAKER;
    end

    // R5: protection moves only right after a period completes
    a_r5_prot_on_done: assert property (@(posedge clk) disable iff (rst)
        !$stable(prot_q) |-> $past(prog_done));

    // R4: a finished period without a new key withdraws authorisation
    a_r4_auth_drops: assert property (@(posedge clk) disable iff (rst)
        (prog_done && !prot_evt) |=> !auth_q);

    // R8: substituted codes are byte-sized
    a_r8_code_width: assert property (@(posedge clk) disable iff (rst)
        (id_mode && rd_addr[15:1] == '0) |-> rd_data[15:8] == 8'h00);

endmodule

// File: tb/unlock_seq_decoder_test.sv
module unlock_seq_decoder_test;

    localparam int CLK_PERIOD = 10;
    localparam int WAIT_CYC   = 6;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ld_valid = 1'b0;
    logic [15:0] ld_addr = '0;
    logic [15:0] ld_data = '0;
    logic        prog_done = 1'b0;
    logic [15:0] rd_addr = '0;
    logic [15:0] arr_rdata = 16'hBEEF;
    logic [15:0] rd_data;
    logic        wr_allow, prot_on, id_mode;

    int n_chk = 0;
    int n_bad = 0;
    bit ended = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    unlock_seq_decoder #(.ID_WAIT(WAIT_CYC)) uut (
        .clk(clk), .rst(rst), .ld_valid(ld_valid), .ld_addr(ld_addr),
        .ld_data(ld_data), .prog_done(prog_done), .rd_addr(rd_addr),
        .arr_rdata(arr_rdata), .rd_data(rd_data), .wr_allow(wr_allow),
        .prot_on(prot_on), .id_mode(id_mode)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic ld(input logic [15:0] a, input logic [15:0] d);
        @(negedge clk);
        ld_valid = 1'b1; ld_addr = a; ld_data = d;
        @(negedge clk);
        ld_valid = 1'b0;
    endtask

    task automatic done_pulse();
        @(negedge clk);
        prog_done = 1'b1;
        @(negedge clk);
        prog_done = 1'b0;
    endtask

    task automatic prefix(input logic [15:0] hi);
        ld(hi | 16'h5555, 16'hAAAA);
        ld(hi | 16'h2AAA, 16'h5555);
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset_state();
        check("R5 prot at power-up", prot_on, 0);
        check("R9 id after reset", id_mode, 0);
        check("R4 open when unprotected", wr_allow, 1);
        check("R8 passthrough", rd_data, 16'hBEEF);
    endtask

    task automatic t_enable();
        prefix(16'h0000);
        ld(16'h5555, 16'hA0A0);
        check("R2 authorised after enable", wr_allow, 1);
        check("R2 prot before period end", prot_on, 0);
        done_pulse();
        check("R2 prot after period end", prot_on, 1);
        check("R4 authorisation ends", wr_allow, 0);
    endtask

    task automatic t_unauth();
        ld(16'h0100, 16'h1234);
        check("R4 bare load blocked", wr_allow, 0);
        done_pulse();
        check("R5 prot kept", prot_on, 1);
    endtask

    task automatic t_bit15();
        prefix(16'h8000);
        ld(16'hD555, 16'hA0A0);
        check("R1 bit15 ignored", wr_allow, 1);
        done_pulse();
        check("R1 period closed", wr_allow, 0);
    endtask

    task automatic t_break();
        ld(16'h5555, 16'hAAAA);
        ld(16'h5555, 16'hAAAA);
        ld(16'h2AAA, 16'h5555);
        ld(16'h5555, 16'hA0A0);
        check("R6 breaking load restarts", wr_allow, 1);
        done_pulse();
        ld(16'h5555, 16'hAAAA);
        ld(16'h1234, 16'h5555);
        ld(16'h2AAA, 16'h5555);
        ld(16'h5555, 16'hA0A0);
        check("R6 broken sequence no effect", wr_allow, 0);
    endtask

    task automatic t_disable();
        prefix(16'h0000);
        ld(16'h5555, 16'h8080);
        prefix(16'h0000);
        ld(16'h5555, 16'h2020);
        check("R3 authorised after disable", wr_allow, 1);
        check("R3 prot before period end", prot_on, 1);
        done_pulse();
        check("R3 prot cleared", prot_on, 0);
        check("R3 open afterwards", wr_allow, 1);
    endtask

    task automatic t_reset_keeps_prot();
        prefix(16'h0000);
        ld(16'h5555, 16'hA0A0);
        done_pulse();
        do_reset();
        check("R5 reset keeps prot", prot_on, 1);
        prefix(16'h0000);
        ld(16'h5555, 16'h8080);
        prefix(16'h0000);
        ld(16'h5555, 16'h2020);
        done_pulse();
        check("R5 restore", prot_on, 0);
    endtask

    task automatic t_ident();
        prefix(16'h0000);
        ld(16'h5555, 16'h9090);
        repeat (WAIT_CYC - 1) @(negedge clk);
        check("R7 entry not early", id_mode, 0);
        @(negedge clk);
        check("R7 entry on time", id_mode, 1);
        rd_addr = 16'h0000; #1;
        check("R8 maker code", rd_data, 16'h001F);
        rd_addr = 16'h0001; #1;
        check("R8 device code", rd_data, 16'h0025);
        rd_addr = 16'h0002; #1;
        check("R8 other address", rd_data, 16'hBEEF);
        rd_addr = 16'h8000; #1;
        check("R8 bit15 address", rd_data, 16'hBEEF);
        rd_addr = 16'h0000;
        prefix(16'h0000);
        ld(16'h5555, 16'hF0F0);
        repeat (WAIT_CYC - 1) @(negedge clk);
        check("R7 exit not early", id_mode, 1);
        @(negedge clk);
        check("R7 exit on time", id_mode, 0);
        check("R8 array after exit", rd_data, 16'hBEEF);
    endtask

    task automatic t_reset_id();
        prefix(16'h0000);
        ld(16'h5555, 16'h9090);
        repeat (WAIT_CYC) @(negedge clk);
        do_reset();
        check("R9 reset leaves id", id_mode, 0);
        prefix(16'h0000);
        ld(16'h5555, 16'h9090);
        do_reset();
        repeat (WAIT_CYC + 2) @(negedge clk);
        check("R9 pending wait dropped", id_mode, 0);
        ld(16'h5555, 16'hAAAA);
        do_reset();
        ld(16'h2AAA, 16'h5555);
        ld(16'h5555, 16'hA0A0);
        done_pulse();
        check("R9 partial sequence dropped", prot_on, 0);
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset_state();
        t_enable();
        t_unauth();
        t_bit15();
        t_break();
        t_disable();
        t_reset_keeps_prot();
        t_ident();
        t_reset_id();
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

endmodule